// File: doc/BRIEF.md
# LIN Break-Detecting Serial Receiver

This block is the receive side of a serial port for a LIN slave node. It watches one RX line through a two-stage synchronizer. A 16x oversampling clock enable paces it. It assembles 8-bit characters, least significant bit first. Each bit is decided by a majority vote of the three samples around its centre. A finished character lands in a receive data register.

A separate dominant-run counter measures how long the line stays low. When break detection is switched on, a low run of 13 or 14 bit times (chosen by a control bit) raises a break flag. A zero-valued data character is only about nine to ten bit times low, so it cannot reach the threshold. A character whose stop bit is low, and which falls short of the threshold, is reported as a framing error instead.

Software reaches the block through a two-address register port. One address is shared by the data in both directions: a read returns the last received byte, and a write hands a byte to the transmit side. The other address holds the control bits and the status flags.

Top module: `lin_brk_rx`

## Requirements
- R1: An 8-bit character, framed as one low start bit, eight data bits sent LSB first and one high stop bit, each 16 ticks of `os_tick` long, is stored in the receive data register and sets `rx_valid`. Each bit is the majority of its samples at ticks 7, 8 and 9 of the bit, so a one-tick glitch near the bit centre does not change the received value.
- R2: A low pulse that ends before the start-bit centre is dropped: no character is stored, and neither `rx_valid` nor `frm_err` is set.
- R3: With the break enable (control bit 0) clear, no low run of any length sets `brk_flag`. A run long enough to give a low stop bit sets `frm_err` instead.
- R4: With the break enable set and the threshold select (control bit 1) at 0, a low run of at least 13 bit times (208 ticks) sets `brk_flag` once and does not set `frm_err`. A run of 12 bit times sets `frm_err` and does not set `brk_flag`.
- R5: With the break enable set and the threshold select at 1, the threshold is 14 bit times (224 ticks). A 13-bit-time run gives `frm_err` and no break.
- R6: A 0x00 data character never sets `brk_flag`, under either threshold setting. It is received as data 0x00 with `rx_valid` set.
- R7: A character whose stop bit is voted low and whose low run stays under the active threshold sets `frm_err` when the line returns high. It does not store data and does not set `rx_valid`.
- R8: At address 0, a read returns the last received byte. A write places the byte on `tx_byte` and pulses `tx_load` for one cycle, one cycle after the write. The transmit byte and the received byte are separate storage.
- R9: Reset clears the two control bits and the three flags. It leaves both the received byte and `tx_byte` unchanged.
- R10: A read of address 0 clears `rx_valid`. A read of address 1 clears `frm_err` and `brk_flag`. When a flag is set and cleared in the same cycle, setting wins.
- R11: Address 1 reads back as bit 0 break enable, bit 1 threshold select, bit 5 `rx_valid`, bit 6 `frm_err` and bit 7 `brk_flag`, with the other bits 0. A write to address 1 changes only bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rx_in | input | 1 | Serial receive line, idle high |
| bus_addr | input | 1 | Register select: 0 data, 1 control/status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears flags as in R10) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| rx_valid | output | 1 | Received character waiting |
| frm_err | output | 1 | Framing error seen |
| brk_flag | output | 1 | Break detected |
| tx_byte | output | 8 | Byte last written for transmission |
| tx_load | output | 1 | One-cycle pulse after a data write |

## Verification
Two events can land on the same clock edge: the load of a newly received character and a software read of the data address, which clears `rx_valid`. The bench first times, at the ports, the delay from the start edge to the rise of `rx_valid`. On the next character it issues the data read exactly on the load edge. It then expects `rx_valid` to stay set and the read to return the previous byte. A later read must return the new byte and clear the flag.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_BITS = 2'd1,
    RX_HOLD = 2'd2
  } rx_state_e;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  localparam int CB_BRK_EN  = 0;
  localparam int CB_THR_SEL = 1;
  localparam int SB_VALID   = 5;
  localparam int SB_FRM     = 6;
  localparam int SB_BRK     = 7;

endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rx_s
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], rx_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign rx_s = pipe_q[STAGES-1];
endmodule

// File: rtl/lin_rx_frame.sv
module lin_rx_frame
  import lin_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_s,
  input  logic          run_sat,
  output logic          load,
  output logic          frm_set,
  output logic [DW-1:0] shr_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 2);
  localparam logic [CW-1:0] SMP_A   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] SMP_B   = CW'(OSR / 2);
  localparam logic [CW-1:0] SMP_C   = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(OSR - 1);
  localparam logic [BW-1:0] IDX_STOP = BW'(DW + 1);

  rx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] idx_q, idx_d;
  logic [DW-1:0] shr_q, shr_d;
  logic [1:0]    smp_q, smp_d;
  logic          vote;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shr_d   = shr_q;
    smp_d   = smp_q;
    load    = 1'b0;
    frm_set = 1'b0;
    vote    = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx_s) | (smp_q[1] & rx_s);
    if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!rx_s) begin
            st_d  = RX_BITS;
            cnt_d = CW'(1);
            idx_d = '0;
          end
        end
        RX_BITS: begin
          if (cnt_q == CNT_TOP) begin
            cnt_d = '0;
            idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
          if (cnt_q == SMP_A) smp_d[0] = rx_s;
          if (cnt_q == SMP_B) smp_d[1] = rx_s;
          if (cnt_q == SMP_C) begin
            if (idx_q == '0) begin
              if (vote) st_d = RX_IDLE;
            end else if (idx_q == IDX_STOP) begin
              if (vote) begin
                load = 1'b1;
                st_d = RX_IDLE;
              end else begin
                st_d = RX_HOLD;
              end
            end else begin
              shr_d = {vote, shr_q[DW-1:1]};
            end
          end
        end
        RX_HOLD: begin
          if (rx_s) begin
            frm_set = !run_sat;
            st_d    = RX_IDLE;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      shr_q <= '0;
      smp_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      shr_q <= shr_d;
      smp_q <= smp_d;
    end
  end

  assign shr_o = shr_q;

  AST_NO_LOAD_WHILE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_HOLD) |-> !load); // R7
endmodule

// File: rtl/lin_brk_count.sv
module lin_brk_count #(
  parameter int OSR    = 16,
  parameter int THR_LO = 13,
  parameter int THR_HI = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_s,
  input  logic brk_en,
  input  logic thr_sel,
  output logic run_sat,
  output logic brk_hit
);
  localparam int MAXT = OSR * THR_HI;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LIM_LO = CW'(OSR * THR_LO);
  localparam logic [CW-1:0] LIM_HI = CW'(OSR * THR_HI);

  logic [CW-1:0] run_q, run_d, limit, run_inc;
  logic          sat_q, sat_d, hit_q, hit_d;

  always_comb begin
    limit   = thr_sel ? LIM_HI : LIM_LO;
    run_inc = run_q + 1'b1;
    run_d   = run_q;
    sat_d   = sat_q;
    hit_d   = 1'b0;
    if (!brk_en) begin
      run_d = '0;
      sat_d = 1'b0;
    end else if (tick) begin
      if (rx_s) begin
        run_d = '0;
        sat_d = 1'b0;
      end else if (!sat_q) begin
        run_d = run_inc;
        if (run_inc >= limit) begin
          sat_d = 1'b1;
          hit_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      sat_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      run_q <= run_d;
      sat_q <= sat_d;
      hit_q <= hit_d;
    end
  end

  assign run_sat = sat_q;
  assign brk_hit = hit_q;

  AST_BRK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |-> $past(brk_en)); // R3
  AST_BRK_ON_LOW_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |-> !$past(rx_s)); // R4
  AST_BRK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |=> !brk_hit); // R4
endmodule

// File: rtl/lin_rx_regs.sv
module lin_rx_regs
  import lin_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          load,
  input  logic [DW-1:0] rx_byte,
  input  logic          frm_set,
  input  logic          brk_hit,
  output logic          brk_en,
  output logic          thr_sel,
  output logic          rx_valid,
  output logic          frm_err,
  output logic          brk_flag,
  output logic [DW-1:0] tx_byte,
  output logic          tx_load
);
  logic [DW-1:0] rx_q, tx_q;
  logic          en_q, en_d, sel_q, sel_d;
  logic          val_q, val_d, frm_q, frm_d, brk_q, brk_d;
  logic          txl_d, txl_q;
  logic          rd_data, rd_ctrl, wr_data, wr_ctrl;

  always_comb begin
    rd_data = rd_en && (addr == ADDR_DATA);
    rd_ctrl = rd_en && (addr == ADDR_CTRL);
    wr_data = wr_en && (addr == ADDR_DATA);
    wr_ctrl = wr_en && (addr == ADDR_CTRL);

    en_d  = wr_ctrl ? wdata[CB_BRK_EN]  : en_q;
    sel_d = wr_ctrl ? wdata[CB_THR_SEL] : sel_q;

    val_d = val_q;
    if (rd_data) val_d = 1'b0;
    if (load)    val_d = 1'b1;
    frm_d = frm_q;
    brk_d = brk_q;
    if (rd_ctrl) begin
      frm_d = 1'b0;
      brk_d = 1'b0;
    end
    if (frm_set) frm_d = 1'b1;
    if (brk_hit) brk_d = 1'b1;
    txl_d = wr_data;

    rdata = '0;
    if (addr == ADDR_CTRL) begin
      rdata[CB_BRK_EN]  = en_q;
      rdata[CB_THR_SEL] = sel_q;
      rdata[SB_VALID]   = val_q;
      rdata[SB_FRM]     = frm_q;
      rdata[SB_BRK]     = brk_q;
    end else begin
      rdata = rx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      val_q <= 1'b0;
      frm_q <= 1'b0;
      brk_q <= 1'b0;
      txl_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
      val_q <= val_d;
      frm_q <= frm_d;
      brk_q <= brk_d;
      txl_q <= txl_d;
    end
  end

  // data storage is deliberately outside the reset domain
  always_ff @(posedge clk) begin
    if (load) rx_q <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (wr_data) tx_q <= wdata;
  end

  assign brk_en   = en_q;
  assign thr_sel  = sel_q;
  assign rx_valid = val_q;
  assign frm_err  = frm_q;
  assign brk_flag = brk_q;
  assign tx_byte  = tx_q;
  assign tx_load  = txl_q;

  AST_LOAD_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rx_valid); // R10
  AST_FRM_BRK_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_set && brk_hit)); // R7
endmodule

// File: rtl/lin_brk_rx.sv
module lin_brk_rx
  import lin_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DW     = 8,
  parameter int THR_LO = 13,
  parameter int THR_HI = 14,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rx_in,
  input  logic          bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rx_valid,
  output logic          frm_err,
  output logic          brk_flag,
  output logic [DW-1:0] tx_byte,
  output logic          tx_load
);
  logic [1:0]    rst_pipe_q;
  logic          rst_i_n;
  logic          rx_s, run_sat, brk_hit, load, frm_set, brk_en, thr_sel;
  logic [DW-1:0] shr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  lin_rx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .rx_in(rx_in), .rx_s(rx_s)
  );

  lin_rx_frame #(.OSR(OSR), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_i_n), .tick(os_tick), .rx_s(rx_s),
    .run_sat(run_sat), .load(load), .frm_set(frm_set), .shr_o(shr)
  );

  lin_brk_count #(.OSR(OSR), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_count (
    .clk(clk), .rst_n(rst_i_n), .tick(os_tick), .rx_s(rx_s),
    .brk_en(brk_en), .thr_sel(thr_sel), .run_sat(run_sat), .brk_hit(brk_hit)
  );

  lin_rx_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .addr(bus_addr), .wr_en(bus_wr),
    .rd_en(bus_rd), .wdata(bus_wdata), .rdata(bus_rdata), .load(load),
    .rx_byte(shr), .frm_set(frm_set), .brk_hit(brk_hit), .brk_en(brk_en),
    .thr_sel(thr_sel), .rx_valid(rx_valid), .frm_err(frm_err),
    .brk_flag(brk_flag), .tx_byte(tx_byte), .tx_load(tx_load)
  );
endmodule

// File: tb/lin_brk_rx_tb.sv
module lin_brk_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b1;
  logic       rx_in = 1'b1;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, tx_byte;
  logic       rx_valid, frm_err, brk_flag, tx_load;
  int         nchk = 0, nerr = 0, cyc = 0;
  logic [7:0] rd;
  logic [7:0] last_rx;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lin_brk_rx dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .frm_err(frm_err), .brk_flag(brk_flag), .tx_byte(tx_byte), .tx_load(tx_load)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_brk(input int nbits, input logic en, input logic sel);
    return en && (nbits >= (sel ? 14 : 13));
  endfunction

  function automatic logic [7:0] exp_ctrl(input logic en, input logic sel, input logic v,
                                          input logic f, input logic b);
    return {b, f, v, 3'b000, sel, en};
  endfunction

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // gbit >= 0 flips one tick at the centre of that data bit
  task automatic send_char(input logic [7:0] b, input int gbit);
    for (int i = 0; i < 10; i++) begin
      logic v;
      v = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      for (int t = 0; t < 16; t++) begin
        @(negedge clk);
        rx_in = (i == gbit + 1 && t == 8) ? ~v : v;
      end
    end
    @(negedge clk);
    rx_in = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic send_low(input int nbits);
    @(negedge clk);
    rx_in = 1'b0;
    repeat (nbits * 16 - 1) @(negedge clk);
    @(negedge clk);
    rx_in = 1'b1;
    repeat (48) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_low_case(input int nbits, input logic en, input logic sel, input string req);
    logic b;
    bus_write(1'b1, {6'b0, sel, en});
    bus_read(1'b1, rd);
    bus_read(1'b0, rd);
    send_low(nbits);
    b = exp_brk(nbits, en, sel);
    bus_read(1'b1, rd);
    chk(req, rd, exp_ctrl(en, sel, 1'b0, !b, b));
  endtask

  task automatic run_char_case(input logic [7:0] c, input int gbit, input string req);
    logic [7:0] ctl;
    bus_read(1'b0, rd);
    bus_read(1'b1, ctl);
    send_char(c, gbit);
    bus_read(1'b1, rd);
    chk(req, rd, exp_ctrl(ctl[0], ctl[1], 1'b1, 1'b0, 1'b0));
    bus_read(1'b0, rd);
    chk(req, rd, c);
    last_rx = c;
    chk(req, rx_valid, 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL WATCHDOG: actual=timeout expected=finished");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin : main
    int s, d;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 / R11: reset state
    chk("R9 reset flags", {rx_valid, frm_err, brk_flag}, 3'b000);
    bus_read(1'b1, rd);
    chk("R11 reset ctrl", rd, 8'h00);

    // R1: plain characters and glitch rejection
    run_char_case(8'hA5, -1, "R1 char A5");
    run_char_case(8'h01, 0, "R1 glitch on one");
    run_char_case(8'hFD, 1, "R1 glitch on zero");

    // R2: short low pulse
    @(negedge clk); rx_in = 1'b0;
    repeat (5) @(negedge clk); rx_in = 1'b1;
    repeat (200) @(negedge clk);
    bus_read(1'b1, rd);
    chk("R2 false start", rd, 8'h00);

    // R11: status bits not writable
    bus_write(1'b1, 8'hFF);
    bus_read(1'b1, rd);
    chk("R11 ctrl write mask", rd, 8'h03);

    // R3 / R4 / R5 / R7: low runs
    run_low_case(20, 1'b0, 1'b0, "R3 long low, detect off");
    run_low_case(13, 1'b1, 1'b0, "R4 13-bit break");
    run_low_case(12, 1'b1, 1'b0, "R4 12-bit run is framing");
    run_low_case(13, 1'b1, 1'b1, "R5 13-bit under 14 threshold");
    run_low_case(14, 1'b1, 1'b1, "R5 14-bit break");
    run_low_case(10, 1'b1, 1'b0, "R7 stretched zero");

    // R6: zero character under both thresholds
    bus_write(1'b1, 8'h01);
    run_char_case(8'h00, -1, "R6 zero char thr13");
    bus_write(1'b1, 8'h03);
    run_char_case(8'h00, -1, "R6 zero char thr14");

    // R10: load and data read on the same edge
    bus_read(1'b0, rd);
    fork
      send_char(8'h5A, -1);
      begin
        @(negedge clk);
        s = cyc;
        while (!rx_valid) @(negedge clk);
        d = cyc - s;
      end
    join
    chk("R1 load within stop bit", (d >= 144 && d <= 164), 1'b1);
    bus_read(1'b0, rd);
    chk("R10 data read", rd, 8'h5A);
    chk("R10 read clears valid", rx_valid, 1'b0);
    fork
      send_char(8'hC3, -1);
      begin
        @(negedge clk);
        s = cyc;
        while (cyc < s + d - 1) @(negedge clk);
        bus_addr = 1'b0; bus_rd = 1'b1;
        #1 rd = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R10 set wins over read", rx_valid, 1'b1);
        chk("R10 colliding read sees old byte", rd, 8'h5A);
      end
    join
    bus_read(1'b0, rd);
    chk("R10 new byte kept", rd, 8'hC3);
    chk("R10 valid cleared", rx_valid, 1'b0);
    last_rx = 8'hC3;

    // R8: shared address, separate storage
    @(negedge clk);
    bus_addr = 1'b0; bus_wdata = 8'h96; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R8 tx_load pulse", tx_load, 1'b1);
    chk("R8 tx byte", tx_byte, 8'h96);
    @(negedge clk);
    chk("R8 tx_load single", tx_load, 1'b0);
    bus_read(1'b0, rd);
    chk("R8 rx storage separate", rd, 8'hC3);

    // random mix of characters and low runs
    for (int i = 0; i < 24; i++) begin
      logic en, sel;
      en  = 1'($urandom());
      sel = 1'($urandom());
      bus_write(1'b1, {6'b0, sel, en});
      if ($urandom() % 3 == 0) run_low_case(10 + int'($urandom() % 7), en, sel, "R4 random run");
      else run_char_case(8'($urandom()), -1, "R1 random char");
    end

    // R9: reset keeps data storage
    bus_write(1'b0, 8'h3C);
    bus_write(1'b1, 8'h03);
    do_reset();
    bus_read(1'b1, rd);
    chk("R9 ctrl cleared", rd, 8'h00);
    bus_read(1'b0, rd);
    chk("R9 rx byte kept", rd, last_rx);
    chk("R9 tx byte kept", tx_byte, 8'h3C);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule